// File: doc/BRIEF.md
# Clamped Multiply-Add Register Accelerator

This block is a small compute engine that sits on an AXI4-Lite slave port with a 32-bit data bus. Software first writes three signed 32-bit operands into registers: an input value, a coefficient and a bias. It then writes a one to a start bit. After a fixed number of clock cycles the engine stores the coefficient times the input plus the bias into a read-only result register, clamping negative sums to zero. It then raises a done flag that software polls.

The product is formed at full 64-bit width and the bias is added at that width. The sign of the full sum decides the clamp. The stored result is the low 32 bits of the clamped sum. While a computation runs, the operands are frozen and a second start is ignored, so the result always belongs to the operands that were present when the start was accepted. Only word-aligned register offsets decode.

Top module: `relu_mac_lite`

## Requirements
- R1: After reset the done flag (bit 0 at offset 0x04), the result register (0x14), the operand registers (0x08, 0x0C, 0x10) and the control word (0x00) all read 0, and no write or read response is pending.
- R2: Writes to offsets 0x08 (input), 0x0C (coefficient) and 0x10 (bias) store the full 32-bit word, which reads back unchanged while the engine is idle.
- R3: Writing a word with bit 0 set to offset 0x00 while idle clears the done flag and starts a computation. The done flag sets again LATENCY cycles after the write is committed, and the control word reads 0 once the start has been taken.
- R4: Writing a word with bit 0 clear to offset 0x00 has no effect: the done flag and the result keep their values.
- R5: The result is coefficient*input + bias when that sum is greater than zero, and 0 otherwise. For example, (input 4, coefficient 3, bias -20) gives 0, (5, 3, -4) gives 11 and (-2, -7, 3) gives 17.
- R6: The sum is formed at 64 bits and its sign decides the clamp. A positive sum stores only its low 32 bits. A negative 64-bit sum stores 0 even when its low 32 bits are positive.
- R7: While a computation is in flight, writes to the operand registers are ignored and a further start is ignored.
- R8: Writes to the status offset 0x04 and to the result offset 0x14 have no effect.
- R9: Reads of offsets that hold no register, including unaligned ones, return 0. Every read and write response carries OKAY (code 0).
- R10: The write address and write data channels are accepted independently and in either order. The write response comes only after both are taken. A write or read response, with its data, is held until the matching ready signal is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |

## Verification
The embedded properties assume that the master obeys AXI4-Lite. They assume a valid signal is not withdrawn before its handshake, and that the address and data do not change while valid waits. The bench drives every channel through tasks that raise valid at a falling edge and drop it only after a handshake has been seen, so it never leaves that protocol. The freeze and ignore properties also assume a start is only meaningful while idle. The bench therefore deliberately issues operand writes and a second start inside the busy window, which it widens by instancing a longer latency.

// File: rtl/relu_mac_lite.sv
module relu_mac_lite #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int LATENCY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready
);
  localparam int PROD_W = 2 * DATA_W;
  localparam int CNT_W  = $clog2(LATENCY + 1);
  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] OFF_X    = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] OFF_A    = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] OFF_B    = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] OFF_Y    = ADDR_W'('h14);

  logic              aw_full, w_full;
  logic [ADDR_W-1:0] aw_q;
  logic [DATA_W-1:0] w_q;
  logic signed [DATA_W-1:0] x_q, a_q, b_q;
  logic [DATA_W-1:0] y_q;
  logic signed [PROD_W-1:0] prod_q, sum_q;
  logic              busy, done;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] rd_mux;

  assign s_awready = !aw_full;
  assign s_wready  = !w_full;
  assign s_arready = !s_rvalid;
  assign s_bresp   = 2'b00;
  assign s_rresp   = 2'b00;

  wire commit   = aw_full && w_full && !s_bvalid;
  wire start_go = commit && (aw_q == OFF_CTRL) && w_q[0] && !busy;
  wire op_wr    = commit && !busy;
  wire [DATA_W-1:0] clamp_y = (sum_q > 0) ? sum_q[DATA_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_full <= 1'b0;
      aw_q    <= '0;
    end else if (s_awvalid && s_awready) begin
      aw_full <= 1'b1;
      aw_q    <= s_awaddr;
    end else if (commit) begin
      aw_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_full <= 1'b0;
      w_q    <= '0;
    end else if (s_wvalid && s_wready) begin
      w_full <= 1'b1;
      w_q    <= s_wdata;
    end else if (commit) begin
      w_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 s_bvalid <= 1'b0;
    else if (commit)            s_bvalid <= 1'b1;
    else if (s_bready)          s_bvalid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q <= '0;
      a_q <= '0;
      b_q <= '0;
    end else if (op_wr) begin
      if (aw_q == OFF_X) x_q <= w_q;
      if (aw_q == OFF_A) a_q <= w_q;
      if (aw_q == OFF_B) b_q <= w_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod_q <= '0;
      sum_q  <= '0;
    end else begin
      prod_q <= a_q * x_q;
      sum_q  <= prod_q + PROD_W'(b_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
      y_q  <= '0;
    end else if (start_go) begin
      busy <= 1'b1;
      done <= 1'b0;
      cnt  <= CNT_W'(LATENCY - 1);
    end else if (busy) begin
      if (cnt == '0) begin
        busy <= 1'b0;
        done <= 1'b1;
        y_q  <= clamp_y;
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  always_comb begin
    case (s_araddr)
      OFF_STAT: rd_mux = DATA_W'(done);
      OFF_X:    rd_mux = x_q;
      OFF_A:    rd_mux = a_q;
      OFF_B:    rd_mux = b_q;
      OFF_Y:    rd_mux = y_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_rvalid <= 1'b0;
      s_rdata  <= '0;
    end else if (s_arvalid && s_arready) begin
      s_rvalid <= 1'b1;
      s_rdata  <= rd_mux;
    end else if (s_rready) begin
      s_rvalid <= 1'b0;
    end
  end

  // R10
  b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid && !s_bready |=> s_bvalid);
  // R10
  r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));
  // R10
  b_after_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_bvalid) |-> $past(aw_full) && $past(w_full));
  // R7
  op_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(x_q) && $stable(a_q) && $stable(b_q));
  // R3
  done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> !done && busy);
  // R3
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));
  // R5
  y_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(y_q) |-> $rose(done));
  // R9
  ar_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_arvalid && s_arready |=> s_rvalid);
endmodule

// File: tb/sim_relu_mac_lite.sv
module sim_relu_mac_lite;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  awaddr = '0, araddr = '0;
  logic        awvalid = 1'b0, wvalid = 1'b0, bready = 1'b0, arvalid = 1'b0, rready = 1'b0;
  logic [31:0] wdata = '0;
  logic        awready, wready, bvalid, arready, rvalid;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;
  int checks = 0;
  int fails = 0;
  bit ended = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  relu_mac_lite #(.DATA_W(32), .ADDR_W(8), .LATENCY(LAT)) u0 (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic wait_resp(input int hold);
    while (!bvalid) @(negedge clk);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R10 bvalid held", 32'(bvalid), 32'd1);
    end
    chk("R9 bresp OKAY", 32'(bresp), 32'd0);
    bready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bready = 1'b0;
  endtask

  task automatic axi_write(input logic [7:0] ad, input logic [31:0] d, input int hold = 0);
    bit ad_ok = 0;
    bit d_ok = 0;
    @(negedge clk);
    awaddr = ad; wdata = d; awvalid = 1'b1; wvalid = 1'b1;
    while (!(ad_ok && d_ok)) begin
      #1;
      if (awvalid && awready) ad_ok = 1;
      if (wvalid && wready) d_ok = 1;
      @(posedge clk);
      @(negedge clk);
      if (ad_ok) awvalid = 1'b0;
      if (d_ok) wvalid = 1'b0;
    end
    wait_resp(hold);
  endtask

  task automatic axi_read(input logic [7:0] ad, output logic [31:0] d, input int hold = 0);
    logic [31:0] first;
    @(negedge clk);
    araddr = ad; arvalid = 1'b1;
    #1;
    while (!arready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    arvalid = 1'b0;
    first = rdata;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R10 rvalid held", 32'(rvalid), 32'd1);
      chk("R10 rdata stable", rdata, first);
    end
    chk("R9 rresp OKAY", 32'(rresp), 32'd0);
    d = rdata;
    rready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rready = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic test_reset();
    logic [31:0] v;
    chk("R1 bvalid idle", 32'(bvalid), 32'd0);
    chk("R1 rvalid idle", 32'(rvalid), 32'd0);
    axi_read(8'h04, v); chk("R1 done", v, 32'd0);
    axi_read(8'h14, v); chk("R1 result", v, 32'd0);
    axi_read(8'h08, v); chk("R1 input", v, 32'd0);
    axi_read(8'h0C, v); chk("R1 coef", v, 32'd0);
    axi_read(8'h10, v); chk("R1 bias", v, 32'd0);
    axi_read(8'h00, v); chk("R1 ctrl", v, 32'd0);
  endtask

  task automatic test_operands();
    logic [31:0] v;
    axi_write(8'h08, 32'hDEADBEEF);
    axi_write(8'h0C, 32'h80000001);
    axi_write(8'h10, 32'h7FFFFFFF);
    axi_read(8'h08, v); chk("R2 input readback", v, 32'hDEADBEEF);
    axi_read(8'h0C, v); chk("R2 coef readback", v, 32'h80000001);
    axi_read(8'h10, v); chk("R2 bias readback", v, 32'h7FFFFFFF);
  endtask

  task automatic run_case(input int x, input int a, input int b, input logic [31:0] exp, input string req);
    logic [31:0] v;
    axi_write(8'h08, 32'(x));
    axi_write(8'h0C, 32'(a));
    axi_write(8'h10, 32'(b));
    axi_write(8'h00, 32'd1);
    axi_read(8'h04, v); chk("R3 done cleared by start", v, 32'd0);
    axi_read(8'h00, v); chk("R3 ctrl self-clears", v, 32'd0);
    idle(LAT + 4);
    axi_read(8'h04, v); chk("R3 done set", v, 32'd1);
    axi_read(8'h14, v); chk(req, v, exp);
  endtask

  task automatic test_no_effect();
    logic [31:0] v;
    axi_write(8'h00, 32'd0);
    idle(LAT + 2);
    axi_read(8'h04, v); chk("R4 done kept after zero write", v, 32'd1);
    axi_read(8'h14, v); chk("R4 result kept after zero write", v, 32'd17);
    axi_write(8'h14, 32'd123);
    axi_write(8'h04, 32'd0);
    axi_read(8'h14, v); chk("R8 result read-only", v, 32'd17);
    axi_read(8'h04, v); chk("R8 status read-only", v, 32'd1);
  endtask

  task automatic test_busy();
    logic [31:0] v;
    axi_write(8'h08, 32'd5);
    axi_write(8'h0C, 32'd3);
    axi_write(8'h10, -32'sd4);
    axi_write(8'h00, 32'd1);
    axi_write(8'h08, 32'd100);
    axi_write(8'h00, 32'd1);
    idle(2);
    axi_read(8'h04, v); chk("R7 second start ignored", v, 32'd1);
    axi_read(8'h08, v); chk("R7 operand write ignored", v, 32'd5);
    axi_read(8'h14, v); chk("R7 result from frozen operands", v, 32'd11);
  endtask

  task automatic test_unmapped();
    logic [31:0] v;
    axi_read(8'h18, v); chk("R9 unmapped 0x18", v, 32'd0);
    axi_read(8'hFC, v); chk("R9 unmapped 0xFC", v, 32'd0);
    axi_read(8'h09, v); chk("R9 unaligned 0x09", v, 32'd0);
  endtask

  task automatic test_channels();
    logic [31:0] v;
    @(negedge clk);
    awaddr = 8'h08; awvalid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    awvalid = 1'b0;
    chk("R10 address accepted alone", 32'(awready), 32'd0);
    idle(3);
    chk("R10 no response without data", 32'(bvalid), 32'd0);
    wdata = 32'h1234_5678; wvalid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wvalid = 1'b0;
    wait_resp(3);
    axi_read(8'h08, v, 3); chk("R10 split write stored", v, 32'h1234_5678);
    @(negedge clk);
    wdata = 32'h0000_0042; wvalid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wvalid = 1'b0;
    idle(2);
    chk("R10 no response without address", 32'(bvalid), 32'd0);
    awaddr = 8'h10; awvalid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    awvalid = 1'b0;
    wait_resp(0);
    axi_read(8'h10, v); chk("R10 data-first write stored", v, 32'h42);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL R10 watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_operands();
    run_case(4, 3, -20, 32'd0, "R5 negative sum clamps");
    run_case(5, 3, -4, 32'd11, "R5 positive sum");
    run_case(0, 0, 1, 32'd1, "R5 smallest positive");
    run_case(0, 0, 0, 32'd0, "R5 zero sum");
    run_case(32'h10000, 32'h10000, 5, 32'd5, "R6 positive sum truncated");
    run_case(32'h40000000, -4, 7, 32'd0, "R6 negative 64-bit sum clamps");
    run_case(-2, -7, 3, 32'd17, "R5 signed multiply-add");
    test_no_effect();
    test_busy();
    test_unmapped();
    test_channels();
    finish_run();
  end
endmodule